// File: doc/BRIEF.md
# Nested-Loop Multichannel DMA Engine

This block moves data for several independent channels over a single memory port. Each channel has its own transfer descriptor in a small register file. The descriptor holds:

- a source address and a destination address;
- signed per-element source and destination steps;
- an inner-loop byte count;
- an outer-loop iteration count;
- a link target, and enables for the completion interrupt, the error interrupt and the peripheral trigger.

Every 32-bit element is moved in two steps: a read from the current source address, then a write of that data to the current destination address.

A channel is serviced once per start event. A start event is a software start pulse, the channel's own peripheral request line (when enabled), or a link from another channel that has finished its outer loop. One service runs the whole inner loop without interruption. The outer count is then decremented. When it reaches zero, the channel reports completion, can raise its interrupt, and can kick its linked channel. The next pending channel is chosen between services, either by fixed priority or by rotating priority. A memory error aborts the channel.

Top module: `dma_nest_engine`

## Requirements
- R1: Each element is a read (mem_we_o=0) at the channel's current source address, followed by a write (mem_we_o=1) to its current destination address that carries the data returned by that read.
- R2: After each accepted read the source address advances by the sign-extended 16-bit source step. After each accepted write the destination address advances by the sign-extended destination step. The updated addresses persist across services.
- R3: One service moves exactly inner-byte-count/4 elements, and no other channel's access occurs between them.
- R4: Each service decrements the outer count by one. After the service that brings it to zero, done_o for that channel is 1 and active_o is 0. Before that service, done_o is 0 and active_o is 1.
- R5: sw_start_i[c] starts channel c. per_req_i[c] starts it only when the descriptor's peripheral-enable bit is set, and is ignored otherwise.
- R6: When a channel's outer count reaches zero and its link enable is set, the channel named by its link field is started.
- R7: With arb_rr_i=0, the lowest-numbered pending channel is served next.
- R8: With arb_rr_i=1, the search starts at the channel after the one last served and wraps around.
- R9: irq_o[c] is set when channel c's outer count reaches zero, only if its completion interrupt enable is set. A pulse on irq_clr_i[c] clears it.
- R10: A memory error (mem_err_i with mem_ack_i) ends the service at once: no further access for that channel, err_o set, active_o cleared, done_o left 0. irq_o is set only if the error interrupt enable is set.
- R11: After reset, mem_req_o, active_o, done_o, err_o and irq_o are all 0.
- R12: A start event on a channel whose outer count is zero is dropped and produces no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load descriptor of cfg_ch_i; clears its flags |
| cfg_ch_i | input | 2 | Channel to load |
| cfg_saddr_i | input | 32 | Source address |
| cfg_daddr_i | input | 32 | Destination address |
| cfg_soff_i | input | 16 | Signed source step per element |
| cfg_doff_i | input | 16 | Signed destination step per element |
| cfg_nbytes_i | input | 16 | Inner-loop byte count, nonzero multiple of 4 |
| cfg_citer_i | input | 16 | Outer-loop iteration count |
| cfg_link_en_i | input | 1 | Start linked channel at outer-loop end |
| cfg_link_ch_i | input | 2 | Linked channel |
| cfg_int_major_i | input | 1 | Interrupt on outer-loop end |
| cfg_int_err_i | input | 1 | Interrupt on error |
| cfg_hw_en_i | input | 1 | Accept peripheral request |
| sw_start_i | input | 4 | Software start pulse per channel |
| per_req_i | input | 4 | Peripheral request per channel |
| irq_clr_i | input | 4 | Clear interrupt and error flag per channel |
| arb_rr_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| mem_req_o | output | 1 | Memory access request, held until ack |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access accepted |
| mem_err_i | input | 1 | Access failed, valid with ack |
| active_o | output | 4 | Channel started and outer loop not finished |
| done_o | output | 4 | Outer loop finished |
| err_o | output | 4 | Channel aborted by error |
| irq_o | output | 4 | Per-channel interrupt |

## Verification
A sweep covers every channel, every inner byte count from 4 to 16, and positive and negative source and destination steps. Each write is compared with addresses and data computed arithmetically in the bench. This separates wrong step signs, lost address write-back between services and wrong element counts. A double request on one channel while three are pending yields the service order 1,1,2,3 under fixed priority and 1,2,3,1 under rotating priority, so the two arbitration modes are told apart. Separate stimulus covers these cases:

- errors on a read and on a write;
- a start on an exhausted channel;
- a disabled peripheral request;
- a linked chain.

Each of these is observed through the write log and the status outputs.

// File: rtl/dma_nest_pkg.sv
package dma_nest_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 16;
  localparam int CNT_W  = 16;
  localparam int ELEM_B = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} xfer_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] saddr;
    logic [ADDR_W-1:0] daddr;
    logic [OFF_W-1:0]  soff;
    logic [OFF_W-1:0]  doff;
    logic [CNT_W-1:0]  nbytes;
    logic [CNT_W-1:0]  citer;
  } desc_t;

  function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction
endpackage

// File: rtl/dma_nest_arb.sv
module dma_nest_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rr_mode_i,
  input  logic              take_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  logic [CH_W-1:0] last_q;

  always_comb begin
    logic found;
    int unsigned cand;
    found = 1'b0;
    idx_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rr_mode_i) begin
        cand = int'(last_q) + 1 + k;
        if (cand >= NUM_CH) cand = cand - NUM_CH;
      end else begin
        cand = k;
      end
      if (!found && req_i[cand]) begin
        found = 1'b1;
        idx_o = CH_W'(cand);
      end
    end
    any_o = |req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= CH_W'(NUM_CH - 1);
    else if (take_i) last_q <= idx_o;
  end
endmodule

// File: rtl/dma_nest_regs.sv
module dma_nest_regs import dma_nest_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  desc_t             cfg_desc_i,
  input  logic              cfg_link_en_i,
  input  logic [CH_W-1:0]   cfg_link_ch_i,
  input  logic              cfg_int_major_i,
  input  logic              cfg_int_err_i,
  input  logic              cfg_hw_en_i,
  input  logic [NUM_CH-1:0] sw_start_i,
  input  logic [NUM_CH-1:0] per_req_i,
  input  logic [NUM_CH-1:0] irq_clr_i,
  input  logic              take_i,
  input  logic [CH_W-1:0]   take_ch_i,
  input  logic [CH_W-1:0]   eng_ch_i,
  input  logic              src_step_i,
  input  logic              dst_step_i,
  input  logic              minor_done_i,
  input  logic              err_hit_i,
  output desc_t             cur_desc_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] active_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] err_o,
  output logic [NUM_CH-1:0] irq_o
);
  desc_t           desc_q    [NUM_CH];
  logic [CH_W-1:0] link_ch_q [NUM_CH];
  logic [NUM_CH-1:0] link_en_q, int_major_q, int_err_q, hw_en_q;
  logic [NUM_CH-1:0] pend_q, active_q, done_q, err_q, irq_q;
  logic [NUM_CH-1:0] start_ok, end_vec, err_vec, sel_vec;
  logic              major_end;

  assign cur_desc_o = desc_q[eng_ch_i];
  assign major_end  = minor_done_i && (desc_q[eng_ch_i].citer == CNT_W'(1));

  always_comb begin
    logic [CNT_W-1:0] eff_cnt;
    logic             link_hit;
    for (int c = 0; c < NUM_CH; c++) begin
      sel_vec[c] = (eng_ch_i == CH_W'(c));
      link_hit   = major_end && link_en_q[eng_ch_i] && (link_ch_q[eng_ch_i] == CH_W'(c));
      // count as it will be after this cycle's decrement
      eff_cnt    = (minor_done_i && sel_vec[c]) ? desc_q[c].citer - CNT_W'(1) : desc_q[c].citer;
      start_ok[c] = (sw_start_i[c] || (per_req_i[c] && hw_en_q[c]) || link_hit) && (eff_cnt != '0);
      end_vec[c]  = major_end && sel_vec[c];
      err_vec[c]  = err_hit_i && sel_vec[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++) begin
        desc_q[c]    <= '0;
        link_ch_q[c] <= '0;
      end
      link_en_q   <= '0;
      int_major_q <= '0;
      int_err_q   <= '0;
      hw_en_q     <= '0;
      pend_q      <= '0;
      active_q    <= '0;
      done_q      <= '0;
      err_q       <= '0;
      irq_q       <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg_we_i && cfg_ch_i == CH_W'(c)) begin
          desc_q[c]      <= cfg_desc_i;
          link_ch_q[c]   <= cfg_link_ch_i;
          link_en_q[c]   <= cfg_link_en_i;
          int_major_q[c] <= cfg_int_major_i;
          int_err_q[c]   <= cfg_int_err_i;
          hw_en_q[c]     <= cfg_hw_en_i;
          pend_q[c]      <= 1'b0;
          active_q[c]    <= 1'b0;
          done_q[c]      <= 1'b0;
          err_q[c]       <= 1'b0;
          irq_q[c]       <= 1'b0;
        end else begin
          if (sel_vec[c] && src_step_i)
            desc_q[c].saddr <= desc_q[c].saddr + sext_off(desc_q[c].soff);
          if (sel_vec[c] && dst_step_i)
            desc_q[c].daddr <= desc_q[c].daddr + sext_off(desc_q[c].doff);
          if (sel_vec[c] && minor_done_i)
            desc_q[c].citer <= desc_q[c].citer - CNT_W'(1);

          if (err_vec[c])                            pend_q[c] <= 1'b0;
          else if (start_ok[c])                      pend_q[c] <= 1'b1;
          else if (take_i && take_ch_i == CH_W'(c))  pend_q[c] <= 1'b0;

          if (err_vec[c] || end_vec[c]) active_q[c] <= 1'b0;
          else if (start_ok[c])         active_q[c] <= 1'b1;

          if (end_vec[c])       done_q[c] <= 1'b1;
          else if (start_ok[c]) done_q[c] <= 1'b0;

          if (err_vec[c])        err_q[c] <= 1'b1;
          else if (irq_clr_i[c]) err_q[c] <= 1'b0;

          if ((end_vec[c] && int_major_q[c]) || (err_vec[c] && int_err_q[c])) irq_q[c] <= 1'b1;
          else if (irq_clr_i[c])                                             irq_q[c] <= 1'b0;
        end
      end
    end
  end

  assign pend_o   = pend_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/dma_nest_xfer.sv
module dma_nest_xfer import dma_nest_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_pend_i,
  input  logic [CH_W-1:0]   arb_idx_i,
  input  desc_t             cur_desc_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              take_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              src_step_o,
  output logic              dst_step_o,
  output logic              minor_done_o,
  output logic              err_hit_o
);
  xfer_st_e          st_q;
  logic [CH_W-1:0]   ch_q;
  logic [CNT_W-1:0]  moved_q;
  logic [DATA_W-1:0] data_q;
  logic              last_elem;

  assign last_elem = (moved_q + CNT_W'(ELEM_B)) >= cur_desc_i.nbytes;

  always_comb begin
    take_o       = (st_q == ST_IDLE) && any_pend_i;
    mem_req_o    = (st_q == ST_RD) || (st_q == ST_WR);
    mem_we_o     = (st_q == ST_WR);
    mem_addr_o   = (st_q == ST_WR) ? cur_desc_i.daddr : cur_desc_i.saddr;
    mem_wdata_o  = data_q;
    src_step_o   = (st_q == ST_RD) && mem_ack_i && !mem_err_i;
    dst_step_o   = (st_q == ST_WR) && mem_ack_i && !mem_err_i;
    err_hit_o    = mem_req_o && mem_ack_i && mem_err_i;
    minor_done_o = (st_q == ST_FIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      moved_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_o) begin
          ch_q    <= arb_idx_i;
          moved_q <= '0;
          st_q    <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          if (mem_err_i) st_q <= ST_IDLE;
          else begin
            data_q <= mem_rdata_i;
            st_q   <= ST_WR;
          end
        end
        ST_WR: if (mem_ack_i) begin
          if (mem_err_i) st_q <= ST_IDLE;
          else begin
            moved_q <= moved_q + CNT_W'(ELEM_B);
            st_q    <= last_elem ? ST_FIN : ST_RD;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/dma_nest_engine.sv
module dma_nest_engine import dma_nest_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [ADDR_W-1:0] cfg_saddr_i,
  input  logic [ADDR_W-1:0] cfg_daddr_i,
  input  logic [OFF_W-1:0]  cfg_soff_i,
  input  logic [OFF_W-1:0]  cfg_doff_i,
  input  logic [CNT_W-1:0]  cfg_nbytes_i,
  input  logic [CNT_W-1:0]  cfg_citer_i,
  input  logic              cfg_link_en_i,
  input  logic [CH_W-1:0]   cfg_link_ch_i,
  input  logic              cfg_int_major_i,
  input  logic              cfg_int_err_i,
  input  logic              cfg_hw_en_i,
  input  logic [NUM_CH-1:0] sw_start_i,
  input  logic [NUM_CH-1:0] per_req_i,
  input  logic [NUM_CH-1:0] irq_clr_i,
  input  logic              arb_rr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic [NUM_CH-1:0] active_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] err_o,
  output logic [NUM_CH-1:0] irq_o
);
  desc_t             cfg_desc, cur_desc;
  logic [NUM_CH-1:0] pend;
  logic              any_pend, take, src_step, dst_step, minor_done, err_hit;
  logic [CH_W-1:0]   arb_idx, eng_ch;

  assign cfg_desc = '{saddr: cfg_saddr_i, daddr: cfg_daddr_i, soff: cfg_soff_i,
                      doff: cfg_doff_i, nbytes: cfg_nbytes_i, citer: cfg_citer_i};

  dma_nest_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i,
    .cfg_desc_i(cfg_desc), .cfg_link_en_i, .cfg_link_ch_i,
    .cfg_int_major_i, .cfg_int_err_i, .cfg_hw_en_i,
    .sw_start_i, .per_req_i, .irq_clr_i,
    .take_i(take), .take_ch_i(arb_idx), .eng_ch_i(eng_ch),
    .src_step_i(src_step), .dst_step_i(dst_step),
    .minor_done_i(minor_done), .err_hit_i(err_hit),
    .cur_desc_o(cur_desc), .pend_o(pend),
    .active_o, .done_o, .err_o, .irq_o
  );

  dma_nest_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk_i, .rst_ni, .req_i(pend), .rr_mode_i(arb_rr_i),
    .take_i(take), .any_o(any_pend), .idx_o(arb_idx)
  );

  dma_nest_xfer #(.NUM_CH(NUM_CH)) u_xfer (
    .clk_i, .rst_ni, .any_pend_i(any_pend), .arb_idx_i(arb_idx),
    .cur_desc_i(cur_desc), .mem_rdata_i, .mem_ack_i, .mem_err_i,
    .take_o(take), .ch_o(eng_ch), .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .src_step_o(src_step),
    .dst_step_o(dst_step), .minor_done_o(minor_done), .err_hit_o(err_hit)
  );
endmodule

// File: rtl/dma_nest_engine_chk.sv
module dma_nest_engine_chk import dma_nest_pkg::*; #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic [NUM_CH-1:0] active_o,
  input logic [NUM_CH-1:0] done_o
);
  // R1
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && !mem_err_i) |=> (mem_req_o && mem_we_o));

  // R1
  wdata_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && !mem_err_i) |=> (mem_wdata_o == $past(mem_rdata_i)));

  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

  // R4
  done_active_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_o & active_o) == '0));

  // R10
  err_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i) |=> !mem_req_o);
endmodule

bind dma_nest_engine dma_nest_engine_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_nest_engine_bench.sv
module dma_nest_engine_bench;
  localparam logic [31:0] BAD = 32'hBAD0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [31:0] cfg_saddr = '0, cfg_daddr = '0;
  logic [15:0] cfg_soff = '0, cfg_doff = '0, cfg_nbytes = '0, cfg_citer = '0;
  logic        cfg_link_en = 1'b0;
  logic [1:0]  cfg_link_ch = '0;
  logic        cfg_int_major = 1'b0, cfg_int_err = 1'b0, cfg_hw_en = 1'b0;
  logic [3:0]  sw_start = '0, per_req = '0, irq_clr = '0;
  logic        arb_rr = 1'b0;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  active, done, err, irq;

  int vectors = 0;
  int fails = 0;
  logic [31:0] wa_q[$];
  logic [31:0] wd_q[$];

  always #10 clk = ~clk;

  dma_nest_engine u_dma_nest_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_saddr_i(cfg_saddr), .cfg_daddr_i(cfg_daddr), .cfg_soff_i(cfg_soff),
    .cfg_doff_i(cfg_doff), .cfg_nbytes_i(cfg_nbytes), .cfg_citer_i(cfg_citer),
    .cfg_link_en_i(cfg_link_en), .cfg_link_ch_i(cfg_link_ch),
    .cfg_int_major_i(cfg_int_major), .cfg_int_err_i(cfg_int_err), .cfg_hw_en_i(cfg_hw_en),
    .sw_start_i(sw_start), .per_req_i(per_req), .irq_clr_i(irq_clr), .arb_rr_i(arb_rr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .active_o(active), .done_o(done), .err_o(err), .irq_o(irq)
  );

  // zero-wait memory: data is a function of address
  assign mem_ack   = mem_req;
  assign mem_rdata = mem_addr * 32'd3 + 32'h1234;
  assign mem_err   = mem_req && (mem_addr == BAD);

  always @(posedge clk)
    if (mem_req && mem_ack && mem_we && !mem_err) begin
      wa_q.push_back(mem_addr);
      wd_q.push_back(mem_wdata);
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int c, input logic [31:0] s, input logic [31:0] d,
                      input int so, input int dof, input int nb, input int ci,
                      input bit len, input int lch, input bit im, input bit ie, input bit hw);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(c); cfg_saddr = s; cfg_daddr = d;
    cfg_soff = 16'(so); cfg_doff = 16'(dof); cfg_nbytes = 16'(nb); cfg_citer = 16'(ci);
    cfg_link_en = len; cfg_link_ch = 2'(lch); cfg_int_major = im; cfg_int_err = ie; cfg_hw_en = hw;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_sw(input logic [3:0] m);
    sw_start = m; @(negedge clk); sw_start = '0;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    irq_clr = m; @(negedge clk); irq_clr = '0;
  endtask

  task automatic clear_log();
    wa_q.delete(); wd_q.delete();
  endtask

  initial begin
    cycles(3);
    // R11 reset state
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 flags", {16'h0, active, done, err, irq}, 0);
    rst_n = 1'b1;
    cycles(2);

    // sweep: channel x byte count x step signs
    for (int c = 0; c < 4; c++)
      for (int nbi = 1; nbi <= 4; nbi++)
        for (int sp = 0; sp < 2; sp++)
          for (int dp = 0; dp < 2; dp++) begin
            int so, dof, n;
            logic [31:0] s0, d0;
            bit im;
            so  = sp ? -4 : 4;
            dof = dp ? -8 : 4;
            n   = nbi;
            im  = nbi[0];
            s0  = 32'h1000_0000 + (32'(c) << 12) + 32'h800;
            d0  = 32'h2000_0000 + (32'(c) << 16) + 32'h8000;
            load(c, s0, d0, so, dof, 4 * n, 2, 1'b0, 0, im, 1'b0, 1'b0);
            clear_log();
            pulse_sw(4'(1 << c));
            cycles(30);
            chk("R3 count first service", 32'(wa_q.size()), 32'(n));
            chk("R4 not done mid", 32'(done[c]), 0);
            chk("R4 active mid", 32'(active[c]), 1);
            pulse_sw(4'(1 << c));
            cycles(30);
            chk("R3 count two services", 32'(wa_q.size()), 32'(2 * n));
            for (int k = 0; k < 2 * n && k < wa_q.size(); k++) begin
              logic [31:0] es, ed;
              es = s0 + 32'(k * so);
              ed = d0 + 32'(k * dof);
              chk("R2 dest addr", wa_q[k], ed);
              chk("R1 data", wd_q[k], es * 32'd3 + 32'h1234);
            end
            chk("R4 done at end", 32'(done[c]), 1);
            chk("R4 inactive at end", 32'(active[c]), 0);
            chk("R9 irq per enable", 32'(irq[c]), 32'(im));
            pulse_sw(4'(1 << c));
            cycles(20);
            chk("R12 exhausted start dropped", 32'(wa_q.size()), 32'(2 * n));
            pulse_clr(4'(1 << c));
            chk("R9 irq cleared", 32'(irq[c]), 0);
          end

    // R5 peripheral request gating
    load(1, 32'h3000_0000, 32'h2001_0000, 4, 4, 4, 1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    clear_log();
    per_req = 4'b0010; @(negedge clk); per_req = '0;
    cycles(20);
    chk("R5 per_req ignored", 32'(wa_q.size()), 0);
    chk("R5 per_req ignored active", 32'(active[1]), 0);
    load(1, 32'h3000_0000, 32'h2001_0000, 4, 4, 4, 1, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    per_req = 4'b0010; @(negedge clk); per_req = '0;
    cycles(20);
    chk("R5 per_req accepted", 32'(wa_q.size()), 1);
    chk("R5 per_req done", 32'(done[1]), 1);

    // R6 link chain 0 -> 2
    load(0, 32'h3100_0000, 32'h2000_0000, 4, 4, 4, 1, 1'b1, 2, 1'b0, 1'b0, 1'b0);
    load(2, 32'h3200_0000, 32'h2002_0000, 4, 4, 8, 1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    clear_log();
    pulse_sw(4'b0001);
    cycles(40);
    chk("R6 link count", 32'(wa_q.size()), 3);
    if (wa_q.size() == 3) begin
      chk("R6 first is ch0", 32'(wa_q[0][17:16]), 0);
      chk("R6 then ch2", 32'(wa_q[1][17:16]), 2);
      chk("R6 then ch2 b", 32'(wa_q[2][17:16]), 2);
    end
    chk("R6 ch2 done", 32'(done[2]), 1);

    // R7 / R8 arbitration order
    for (int mode = 0; mode < 2; mode++) begin
      int exp_ch[4];
      if (mode == 0) exp_ch = '{1, 1, 2, 3};
      else           exp_ch = '{1, 2, 3, 1};
      arb_rr = mode[0];
      for (int c = 1; c < 4; c++)
        load(c, 32'h3000_0000 + (32'(c) << 12), 32'h2000_0000 + (32'(c) << 16),
             4, 4, 16, 4, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      clear_log();
      pulse_sw(4'b1110);
      cycles(3);
      pulse_sw(4'b0010);
      cycles(120);
      chk(mode ? "R8 count" : "R7 count", 32'(wa_q.size()), 16);
      for (int i = 0; i < 16 && i < wa_q.size(); i++)
        chk(mode ? "R8 R3 order" : "R7 R3 order", 32'(wa_q[i][17:16]), 32'(exp_ch[i / 4]));
    end
    arb_rr = 1'b0;

    // R10 error on read, error irq enabled
    load(0, BAD, 32'h2000_0000, 4, 4, 8, 3, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    clear_log();
    pulse_sw(4'b0001);
    cycles(20);
    chk("R10 read err no write", 32'(wa_q.size()), 0);
    chk("R10 err flag", 32'(err[0]), 1);
    chk("R10 inactive", 32'(active[0]), 0);
    chk("R10 not done", 32'(done[0]), 0);
    chk("R10 irq on", 32'(irq[0]), 1);
    pulse_clr(4'b0001);
    chk("R10 err cleared", 32'(err[0]), 0);

    // R10 error on second write, error irq disabled
    load(3, 32'h3300_0000, BAD - 32'd4, 4, 4, 12, 3, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    clear_log();
    pulse_sw(4'b1000);
    cycles(20);
    chk("R10 write err one write", 32'(wa_q.size()), 1);
    chk("R10 err flag ch3", 32'(err[3]), 1);
    chk("R10 irq off", 32'(irq[3]), 0);
    chk("R10 no req after err", 32'(mem_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule